// File: doc/BRIEF.md
# Multi-Chain Single-Input-Change Pattern Generator

This block produces low-switching test stimulus for a set of parallel scan chains. A pseudo-random seed, one bit per chain, comes from a small linear feedback shift register. A twisted-ring (Johnson) codeword, one bit per scan cell position, is combined with it. Each chain output is the XOR of that chain's seed bit with one codeword bit. While a chain is loaded, the codeword rotates by one position per clock. As a result, each chain sees a stream in which few bits change from one clock to the next, and the stream still differs from chain to chain.

Two sequencing modes are provided, and the `per_clk` input picks one when a run starts. In scan mode, each vector takes a STEP cycle that advances the codeword one normal Johnson step, then CHAIN_LEN SHIFT cycles with scan enable high, then one CAPTURE cycle with scan enable low. In clock mode, the APPLY state drives one complete parallel vector on every clock and the codeword steps on every clock. In both modes a seed is used for 2·CHAIN_LEN codewords before the register advances to the next seed. After NSEEDS seeds the block stops in DONE.

The sequencer states and their transitions are:
- IDLE→STEP or IDLE→APPLY on start.
- STEP→SHIFT always.
- SHIFT→SHIFT until the last shift, then SHIFT→CAPTURE.
- CAPTURE→STEP to take the next vector or the next seed.
- CAPTURE→DONE after the final vector.
- APPLY→APPLY until the final vector, then APPLY→DONE.
- DONE→STEP or DONE→APPLY on a new start.

Top module: `msic_pattern_gen`

## Requirements
- R1: During and after reset, and until the first start, scan_en, pat_valid and done are 0 and scan_in is all zero.
- R2: A start pulse seen in IDLE or DONE loads the seed register with SEED_INIT and clears the codeword to all zeros. The per_clk value sampled on that same clock selects the mode, 1 for clock mode and 0 for scan mode. While a run is in progress, start and per_clk have no effect on any output.
- R3: In scan mode each vector occupies exactly CHAIN_LEN+2 cycles, in this order: one STEP cycle (scan_en=0, pat_valid=0), then CHAIN_LEN SHIFT cycles (scan_en=1, pat_valid=1), then one CAPTURE cycle (scan_en=0, pat_valid=0).
- R4: On shift cycle t (t=0..CHAIN_LEN-1) of a vector, chain i drives scan_in[i] = seed[i] XOR J[(i−t) mod CHAIN_LEN], where J is the codeword after that vector's normal step. Between two consecutive shift cycles, at most 2 bits of scan_in change.
- R5: A normal codeword step shifts J one place toward the higher index and puts the inverse of the old top bit J[CHAIN_LEN-1] into J[0]. Starting from zero, the codeword therefore passes through 2·CHAIN_LEN distinct words and returns to zero.
- R6: A seed is used for 2·CHAIN_LEN vectors. The next seed is {seed[NCHAIN-2:0], XOR of the seed bits selected by TAP_MASK}. The default is NCHAIN=4 with TAP_MASK=4'b1100, a maximal-length setting. The seed is never zero.
- R7: In clock mode, every clock of the run drives pat_valid=1 and scan_en=0 with scan_in[i] = seed[i] XOR J[i mod CHAIN_LEN]. The first vector of each seed uses J=0, and J takes one normal step per clock. Within one seed, consecutive vectors differ in at most 1 bit.
- R8: done goes to 1 on the clock after the last vector of the last seed and stays at 1 until the next start. A start in DONE begins a new run.
- R9: Whenever pat_valid is 0, scan_in is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken in IDLE or DONE only) |
| per_clk | input | 1 | Mode sampled at start: 1 clock mode, 0 scan mode |
| scan_in | output | NCHAIN | One stimulus bit per chain |
| scan_en | output | 1 | High during shift cycles, low for capture |
| pat_valid | output | 1 | scan_in carries a pattern bit this cycle |
| done | output | 1 | All seeds applied |

## Verification
Every output comes from registers, so a start sampled on one rising edge first shows its effect in the cycle after that edge. The first pattern appears one cycle later in scan mode, after the STEP cycle, and in that same cycle in clock mode. A reset is seen at once, because it is asynchronous. The reference model places exactly one copy of the pre-start state at the head of its queue of per-cycle expectations, and compares every output at each falling edge, away from the edge where the design changes. Each codeword rotation and each seed change is therefore checked in the cycle it is due. Start pulses given during a run leave that queue untouched, so any reaction to them shows up as a mismatch.

// File: rtl/msic_pkg.sv
package msic_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_STEP    = 3'd1,
        ST_SHIFT   = 3'd2,
        ST_CAPTURE = 3'd3,
        ST_APPLY   = 3'd4,
        ST_DONE    = 3'd5
    } msic_state_e;

endpackage

// File: rtl/msic_seed_lfsr.sv
module msic_seed_lfsr #(
    parameter int                NCHAIN    = 4,
    parameter logic [NCHAIN-1:0] TAP_MASK  = 4'b1100,
    parameter logic [NCHAIN-1:0] SEED_INIT = 4'b0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    output logic [NCHAIN-1:0] seed
);

    logic [NCHAIN-1:0] seed_q;
    logic              fb;

    assign fb = ^(seed_q & TAP_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seed_q <= SEED_INIT;
        end else if (load) begin
            seed_q <= SEED_INIT;
        end else if (adv) begin
            seed_q <= {seed_q[NCHAIN-2:0], fb};
        end
    end

    assign seed = seed_q;

    p_seed_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seed_q != '0);

    p_seed_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !adv |=> $stable(seed_q));

endmodule

// File: rtl/msic_johnson_reg.sv
module msic_johnson_reg #(
    parameter int CHAIN_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 step,
    input  logic                 rot,
    output logic [CHAIN_LEN-1:0] word
);

    logic [CHAIN_LEN-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (clr) begin
            word_q <= '0;
        end else if (step) begin
            word_q <= {word_q[CHAIN_LEN-2:0], ~word_q[CHAIN_LEN-1]};
        end else if (rot) begin
            word_q <= {word_q[CHAIN_LEN-2:0], word_q[CHAIN_LEN-1]};
        end
    end

    assign word = word_q;

    p_step_one_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step && !clr |=> $countones(word_q ^ $past(word_q)) == 1);

    p_rot_keeps_weight_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rot && !step && !clr |=> $countones(word_q) == $countones($past(word_q)));

endmodule

// File: rtl/msic_seq_fsm.sv
module msic_seq_fsm
    import msic_pkg::*;
#(
    parameter int CHAIN_LEN = 8,
    parameter int NSEEDS    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic per_clk,
    output logic lfsr_load,
    output logic lfsr_adv,
    output logic j_clr,
    output logic j_step,
    output logic j_rot,
    output logic scan_en,
    output logic pat_valid,
    output logic done
);

    localparam int SH_W   = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam int VEC_W  = $clog2(2 * CHAIN_LEN);
    localparam int SEED_W = (NSEEDS > 1) ? $clog2(NSEEDS) : 1;
    localparam logic [SH_W-1:0]   SH_LAST   = SH_W'(CHAIN_LEN - 1);
    localparam logic [VEC_W-1:0]  VEC_LAST  = VEC_W'(2 * CHAIN_LEN - 1);
    localparam logic [SEED_W-1:0] SEED_LAST = SEED_W'(NSEEDS - 1);

    msic_state_e       state_q, state_d;
    logic [SH_W-1:0]   sh_q;
    logic [VEC_W-1:0]  vec_q;
    logic [SEED_W-1:0] sd_q;
    logic              go, sh_last, vec_last, seed_last;

    assign sh_last   = (sh_q == SH_LAST);
    assign vec_last  = (vec_q == VEC_LAST);
    assign seed_last = (sd_q == SEED_LAST);
    assign go        = start && (state_q == ST_IDLE || state_q == ST_DONE);

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (start) state_d = per_clk ? ST_APPLY : ST_STEP;
            ST_STEP:          state_d = ST_SHIFT;
            ST_SHIFT:         if (sh_last) state_d = ST_CAPTURE;
            ST_CAPTURE:       state_d = (vec_last && seed_last) ? ST_DONE : ST_STEP;
            ST_APPLY:         if (vec_last && seed_last) state_d = ST_DONE;
            default:          state_d = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sh_q    <= '0;
            vec_q   <= '0;
            sd_q    <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        sh_q  <= '0;
                        vec_q <= '0;
                        sd_q  <= '0;
                    end
                end
                ST_STEP:  sh_q <= '0;
                ST_SHIFT: sh_q <= sh_q + 1'b1;
                ST_CAPTURE, ST_APPLY: begin
                    if (vec_last) begin
                        vec_q <= '0;
                        if (!seed_last) sd_q <= sd_q + 1'b1;
                    end else begin
                        vec_q <= vec_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs and strobes
    always_comb begin
        lfsr_load = go;
        j_clr     = go;
        lfsr_adv  = 1'b0;
        j_step    = 1'b0;
        j_rot     = 1'b0;
        scan_en   = 1'b0;
        pat_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_STEP:  j_step = 1'b1;
            ST_SHIFT: begin
                j_rot     = 1'b1;
                scan_en   = 1'b1;
                pat_valid = 1'b1;
            end
            ST_CAPTURE: lfsr_adv = vec_last && !seed_last;
            ST_APPLY: begin
                j_step    = 1'b1;
                pat_valid = 1'b1;
                lfsr_adv  = vec_last && !seed_last;
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    p_capture_after_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SHIFT && sh_last |=> state_q == ST_CAPTURE && !scan_en);

    p_step_before_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SHIFT && $past(state_q) != ST_SHIFT |-> $past(state_q) == ST_STEP);

    p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);

    p_busy_ignores_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start && state_q != ST_IDLE && state_q != ST_DONE |-> !lfsr_load && !j_clr);

endmodule

// File: rtl/msic_pattern_gen.sv
module msic_pattern_gen #(
    parameter int                NCHAIN    = 4,
    parameter int                CHAIN_LEN = 8,
    parameter int                NSEEDS    = 3,
    parameter logic [NCHAIN-1:0] TAP_MASK  = 4'b1100,
    parameter logic [NCHAIN-1:0] SEED_INIT = 4'b0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              per_clk,
    output logic [NCHAIN-1:0] scan_in,
    output logic              scan_en,
    output logic              pat_valid,
    output logic              done
);

    logic                 lfsr_load, lfsr_adv, j_clr, j_step, j_rot;
    logic [NCHAIN-1:0]    seed;
    logic [CHAIN_LEN-1:0] word;

    msic_seq_fsm #(.CHAIN_LEN(CHAIN_LEN), .NSEEDS(NSEEDS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .per_clk   (per_clk),
        .lfsr_load (lfsr_load),
        .lfsr_adv  (lfsr_adv),
        .j_clr     (j_clr),
        .j_step    (j_step),
        .j_rot     (j_rot),
        .scan_en   (scan_en),
        .pat_valid (pat_valid),
        .done      (done)
    );

    msic_seed_lfsr #(.NCHAIN(NCHAIN), .TAP_MASK(TAP_MASK), .SEED_INIT(SEED_INIT)) u_seed (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (lfsr_load),
        .adv   (lfsr_adv),
        .seed  (seed)
    );

    msic_johnson_reg #(.CHAIN_LEN(CHAIN_LEN)) u_jc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (j_clr),
        .step  (j_step),
        .rot   (j_rot),
        .word  (word)
    );

    // per-chain XOR: chain i watches codeword position i mod CHAIN_LEN
    for (genvar i = 0; i < NCHAIN; i++) begin : g_chain
        assign scan_in[i] = pat_valid & (seed[i] ^ word[i % CHAIN_LEN]);
    end

    p_scan_sic_r4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en && $past(scan_en) |-> $countones(scan_in ^ $past(scan_in)) <= 2);

    p_clk_sic_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pat_valid && !scan_en && $past(pat_valid && !scan_en) && $stable(seed)
        |-> $countones(scan_in ^ $past(scan_in)) <= 1);

    p_quiet_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pat_valid) |-> scan_in == '0);

endmodule

// File: tb/msic_pattern_gen_test.sv
module msic_pattern_gen_test;

    localparam int             CLK_PERIOD = 10;
    localparam int             NCH   = 4;
    localparam int             LEN   = 8;
    localparam int             NSEED = 3;
    localparam logic [NCH-1:0] TAPS  = 4'b1100;
    localparam logic [NCH-1:0] SEED0 = 4'b0001;
    localparam int             WD_CYCLES = 20000;

    typedef struct {
        bit             se;
        bit             pv;
        bit             dn;
        logic [NCH-1:0] si;
        int             ctl;
        int             dat;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           per_clk = 1'b0;
    logic [NCH-1:0] scan_in;
    logic           scan_en, pat_valid, done;

    exp_t q[$];
    exp_t rest;
    int   n_checks = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   ign_until = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msic_pattern_gen #(.NCHAIN(NCH), .CHAIN_LEN(LEN), .NSEEDS(NSEED),
                       .TAP_MASK(TAPS), .SEED_INIT(SEED0)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .per_clk(per_clk),
        .scan_in(scan_in), .scan_en(scan_en), .pat_valid(pat_valid), .done(done)
    );

    function automatic string tag(input int c);
        case (c)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    // codeword after n normal steps from zero (R5)
    function automatic logic [LEN-1:0] jval(input int n);
        logic [LEN-1:0] r;
        for (int k = 0; k < LEN; k++)
            r[k] = (n <= LEN) ? (k < n) : (k >= n - LEN);
        return r;
    endfunction

    // next seed (R6)
    function automatic logic [NCH-1:0] seed_next(input logic [NCH-1:0] s);
        return {s[NCH-2:0], ^(s & TAPS)};
    endfunction

    function automatic exp_t mk(input bit se, input bit pv, input bit dn,
                                input logic [NCH-1:0] si, input int ctl, input int dat);
        exp_t e;
        e.se = se; e.pv = pv; e.dn = dn; e.si = si; e.ctl = ctl; e.dat = dat;
        return e;
    endfunction

    task automatic chk(input string rq, input string what, input logic [NCH-1:0] act,
                       input logic [NCH-1:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d: actual %b expected %b", rq, what, cyc, act, expv);
        end
    endtask

    // reference comparison, every falling edge
    always @(negedge clk) begin
        exp_t e;
        int   cc, dc;
        cyc++;
        if (cyc >= WD_CYCLES) begin
            n_fail++;
            $display("FAIL R8 watchdog: actual no end expected end by cycle %0d", WD_CYCLES);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
        if (q.size() > 0) e = q.pop_front();
        else              e = rest;
        cc = (cyc < ign_until) ? 2 : e.ctl;
        dc = (cyc < ign_until) ? 2 : e.dat;
        chk(tag(cc), "scan_en",   NCH'(scan_en),   NCH'(e.se));
        chk(tag(cc), "pat_valid", NCH'(pat_valid), NCH'(e.pv));
        chk(tag(e.dn ? 8 : cc), "done", NCH'(done), NCH'(e.dn));
        chk(tag(dc), "scan_in",   scan_in,         e.si);
    end

    task automatic launch(input bit clk_mode);
        logic [NCH-1:0] s, si;
        logic [LEN-1:0] j;
        q.push_back(rest);      // the cycle before the start edge lands
        s = SEED0;
        for (int k = 0; k < NSEED; k++) begin
            if (!clk_mode) begin
                for (int v = 1; v <= 2 * LEN; v++) begin
                    j = jval(v);
                    q.push_back(mk(0, 0, 0, '0, 3, 9));            // STEP (R3, R9)
                    for (int t = 0; t < LEN; t++) begin
                        for (int i = 0; i < NCH; i++)
                            si[i] = s[i] ^ j[(((i - t) % LEN) + LEN) % LEN];
                        q.push_back(mk(1, 1, 0, si, 3,
                                       (t == 0) ? 5 : ((k == 0) ? 4 : 6)));  // R4 / R5 / R6
                    end
                    q.push_back(mk(0, 0, 0, '0, 3, 9));            // CAPTURE (R3, R9)
                end
            end else begin
                for (int n = 0; n < 2 * LEN; n++) begin
                    j = jval(n);
                    for (int i = 0; i < NCH; i++) si[i] = s[i] ^ j[i % LEN];
                    q.push_back(mk(0, 1, 0, si, 7, (k == 0) ? 7 : 6));  // R7 / R6
                end
            end
            s = seed_next(s);
        end
        rest = mk(0, 0, 1, '0, 8, 8);                              // DONE held (R8)
        per_clk = clk_mode;
        start   = 1'b1;
        @(posedge clk); #1;
        start   = 1'b0;
        per_clk = 1'b0;
    endtask

    initial begin
        rest = mk(0, 0, 0, '0, 1, 1);                              // reset/idle (R1)
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        // scan mode run, with start and mode toggled mid-run (R2)
        launch(1'b0);
        repeat (30) @(posedge clk);
        #1;
        ign_until = cyc + 40;
        start = 1'b1; per_clk = 1'b1;
        @(posedge clk); #1;
        start = 1'b0; per_clk = 1'b0;
        wait (q.size() == 0);
        repeat (6) @(posedge clk);
        #1;
        // clock mode from DONE (R7, R8)
        launch(1'b1);
        wait (q.size() == 0);
        repeat (4) @(posedge clk);
        #1;
        // scan run interrupted by reset (R1)
        launch(1'b0);
        repeat (50) @(posedge clk);
        #1;
        rst_n = 1'b0;
        q.delete();
        rest = mk(0, 0, 0, '0, 1, 1);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        launch(1'b1);
        wait (q.size() == 0);
        repeat (4) @(posedge clk);
        #2;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule